// File: doc/BRIEF.md
# Frequency Synthesizer Divider Configuration and Bypass Control

This block is the digital control section of a clock synthesizer. It holds three configuration fields: a feedback divide value M (9 bits), an output divide code N (2 bits) and a test-select code T (3 bits). M and N can come from static parallel pins while an active-low parallel-load input is asserted. All three fields can be written through a three-wire serial port with a serial clock, a data line and a load strobe. After power-up, board straps can set a working frequency. Software can later retune it over the serial port.

The block runs on one fast clock `clk`, which stands for the oscillator-rate clock. The serial pins are asynchronous and pass through a synchronizer. An edge detector then turns them into single-cycle events. The M down-counter produces a one-cycle pulse every M ticks. The N divider toggles `fout` once every 1, 2, 4 or 8 ticks. In normal operation a tick occurs on every `clk` cycle.

One test code switches the block into PLL bypass. In bypass, each synchronized rising edge of the serial clock is one divider tick, so a slow hand-driven clock can step the output through the clock tree for board debug. A registered multiplexer selects the internal node that appears on `test_out`.

Top module: `clksyn_ctrl`

## Requirements
- R1: While `rst_n` is low, `fout` and `test_out` are 0. Reset leaves M=0, N=00 and T=000.
- R2: Each rising edge of `sclk` while `sload` is low shifts `sdata` into a 14-bit register. Fields go in most significant bit first: T2, T1, T0, N1, N0, M8 to M0. A rising edge of `sload` copies the register into T, N and M.
- R3: Only the last 14 bits shifted before the load strobe take effect. Earlier bits are shifted out and discarded.
- R4: `test_out` is registered one `clk` cycle after its source. The sources by T code are: 000, 101 and 111 give constant 0; 001 gives the shift register's most significant bit; 010 gives `ref_clk`; 011 gives the M pulse; 100 gives `fout`; 110 gives the M pulse in bypass.
- R5: Outside bypass, the M counter pulses once every M `clk` cycles, with each pulse lasting one cycle. M=0 behaves as M=1, which gives a continuous high level.
- R6: `fout` toggles once every 1, 2, 4 or 8 ticks for N codes 00, 01, 10 and 11 respectively.
- R7: While `pload_n` is low, N follows `pn`, M follows `pm`, T is forced to 000 and `test_out` goes low. T stays 000 after `pload_n` returns high.
- R8: A serial load strobe that arrives while `pload_n` is low has no effect on T.
- R9: With T=110, the dividers advance exactly once per synchronized rising edge of `sclk`. Without such edges, `fout` and `test_out` hold.
- R10: In bypass, `test_out` pulses once every M rising edges of `sclk`. `fout` toggles once every N-ratio rising edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock level, routed to the test output |
| sclk | input | 1 | Serial port clock, asynchronous |
| sdata | input | 1 | Serial port data, asynchronous |
| sload | input | 1 | Serial port load strobe, asynchronous |
| pload_n | input | 1 | Active-low parallel load enable |
| pm | input | 9 | Parallel M value |
| pn | input | 2 | Parallel N code |
| fout | output | 1 | Divided main clock output |
| test_out | output | 1 | Registered test-node output |

## Verification
Random serial writes with M from 0 to 47 and all four N codes check the pulse period and the toggle rate. Each is counted over a window that is an exact multiple of the period, so the count is the same at any phase. Because M=0 and M=1 give the same continuous level, they separate the "zero means one" rule from an off-by-one counter. Directed patterns cover the other behaviour. Leading junk bits before a write show that only the newest 14 bits count. Extra shifts after a load walk the stored stream across the shift-output code. In bypass, bursts of serial clock edges produce exact pulse and toggle counts, and a quiet interval shows that both outputs hold when no edges arrive. A parallel load is applied on top of a serial strobe to show that the parallel path takes priority and clears T.

// File: rtl/clksyn_pkg.sv
`timescale 1ns/1ps
package clksyn_pkg;

   localparam int unsigned TSEL_W = 3;

   typedef enum logic [TSEL_W-1:0] {
      TS_LOW    = 3'b000,
      TS_SHIFT  = 3'b001,
      TS_REF    = 3'b010,
      TS_MCNT   = 3'b011,
      TS_FOUT   = 3'b100,
      TS_RSV5   = 3'b101,
      TS_BYPASS = 3'b110,
      TS_RSV7   = 3'b111
   } tsel_e;

endpackage

// File: rtl/csyn_sync.sv
`timescale 1ns/1ps
module csyn_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("csyn_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/csyn_cfg.sv
`timescale 1ns/1ps
module csyn_cfg
   import clksyn_pkg::*;
#(
   parameter int unsigned M_W = 9,
   parameter int unsigned N_W = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sclk_s,
   input  logic           sdata_s,
   input  logic           sload_s,
   input  logic           pload_n,
   input  logic [M_W-1:0] pm,
   input  logic [N_W-1:0] pn,
   output logic [M_W-1:0] m_val,
   output logic [N_W-1:0] n_val,
   output tsel_e          t_val,
   output logic           shift_msb,
   output logic           sclk_rise
);

   localparam int unsigned SH_W  = TSEL_W + N_W + M_W;
   localparam int unsigned N_LSB = M_W;
   localparam int unsigned T_LSB = M_W + N_W;

   logic            sclk_q;
   logic            sload_q;
   logic            sload_rise;
   logic [SH_W-1:0] shift_q;

   assign sclk_rise  = sclk_s & ~sclk_q;
   assign sload_rise = sload_s & ~sload_q;
   assign shift_msb  = shift_q[SH_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sload_q <= 1'b0;
         shift_q <= '0;
      end else begin
         sclk_q  <= sclk_s;
         sload_q <= sload_s;
         if (sclk_rise && !sload_s)
            shift_q <= {shift_q[SH_W-2:0], sdata_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_val <= '0;
         n_val <= '0;
         t_val <= TS_LOW;
      end else if (!pload_n) begin
         m_val <= pm;
         n_val <= pn;
         t_val <= TS_LOW;
      end else if (sload_rise) begin
         m_val <= shift_q[M_W-1:0];
         n_val <= shift_q[N_LSB +: N_W];
         t_val <= tsel_e'(shift_q[T_LSB +: TSEL_W]);
      end
   end

endmodule

// File: rtl/csyn_mdiv.sv
`timescale 1ns/1ps
module csyn_mdiv #(
   parameter int unsigned M_W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [M_W-1:0] m_val,
   output logic           m_pulse
);

   localparam logic [M_W-1:0] ONE = {{(M_W-1){1'b0}}, 1'b1};

   logic [M_W-1:0] cnt_q;
   logic [M_W-1:0] reload;

   always_comb begin
      if (m_val == '0) reload = '0;
      else             reload = m_val - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         m_pulse <= 1'b0;
      end else if (tick) begin
         if (cnt_q == '0) begin
            cnt_q   <= reload;
            m_pulse <= 1'b1;
         end else begin
            cnt_q   <= cnt_q - ONE;
            m_pulse <= 1'b0;
         end
      end else begin
         m_pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/csyn_ndiv.sv
`timescale 1ns/1ps
module csyn_ndiv #(
   parameter int unsigned N_W    = 2,
   parameter bit          LINEAR = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [N_W-1:0] n_val,
   output logic           fout
);

   localparam int unsigned R_W = LINEAR ? N_W + 1 : (1 << N_W);
   localparam logic [R_W-1:0] R_ONE = {{(R_W-1){1'b0}}, 1'b1};

   logic [R_W-1:0] ratio;
   logic [R_W-1:0] cnt_q;

   if (LINEAR) begin : g_linear
      always_comb ratio = {{(R_W-N_W){1'b0}}, n_val} + R_ONE;
   end else begin : g_pow2
      always_comb ratio = R_ONE << n_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         fout  <= 1'b0;
      end else if (tick) begin
         if (cnt_q >= ratio - R_ONE) begin
            cnt_q <= '0;
            fout  <= ~fout;
         end else begin
            cnt_q <= cnt_q + R_ONE;
         end
      end
   end

endmodule

// File: rtl/csyn_testmux.sv
`timescale 1ns/1ps
module csyn_testmux
   import clksyn_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  tsel_e t_val,
   input  logic  shift_msb,
   input  logic  ref_clk,
   input  logic  m_pulse,
   input  logic  fout,
   output logic  test_out
);

   logic sel;

   always_comb begin
      unique case (t_val)
         TS_SHIFT:  sel = shift_msb;
         TS_REF:    sel = ref_clk;
         TS_MCNT,
         TS_BYPASS: sel = m_pulse;
         TS_FOUT:   sel = fout;
         default:   sel = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) test_out <= 1'b0;
      else        test_out <= sel;
   end

endmodule

// File: rtl/clksyn_ctrl.sv
`timescale 1ns/1ps
module clksyn_ctrl
   import clksyn_pkg::*;
#(
   parameter int unsigned M_W         = 9,
   parameter int unsigned N_W         = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          N_LINEAR    = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ref_clk,
   input  logic           sclk,
   input  logic           sdata,
   input  logic           sload,
   input  logic           pload_n,
   input  logic [M_W-1:0] pm,
   input  logic [N_W-1:0] pn,
   output logic           fout,
   output logic           test_out
);

   if (M_W < 1 || M_W > 16) begin : g_bad_mw
      $error("clksyn_ctrl: M_W out of range");
   end
   if (N_W < 1 || N_W > 3) begin : g_bad_nw
      $error("clksyn_ctrl: N_W out of range");
   end

   logic [2:0]     ser_s;
   logic [M_W-1:0] m_val;
   logic [N_W-1:0] n_val;
   tsel_e          t_val;
   logic           shift_msb;
   logic           sclk_rise;
   logic           bypass;
   logic           tick;
   logic           m_pulse;

   csyn_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({sload, sdata, sclk}),
      .dout  (ser_s)
   );

   csyn_cfg #(.M_W(M_W), .N_W(N_W)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (ser_s[0]),
      .sdata_s   (ser_s[1]),
      .sload_s   (ser_s[2]),
      .pload_n   (pload_n),
      .pm        (pm),
      .pn        (pn),
      .m_val     (m_val),
      .n_val     (n_val),
      .t_val     (t_val),
      .shift_msb (shift_msb),
      .sclk_rise (sclk_rise)
   );

   assign bypass = (t_val == TS_BYPASS);
   assign tick   = bypass ? sclk_rise : 1'b1;

   csyn_mdiv #(.M_W(M_W)) i_mdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .m_val   (m_val),
      .m_pulse (m_pulse)
   );

   csyn_ndiv #(.N_W(N_W), .LINEAR(N_LINEAR)) i_ndiv (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .n_val (n_val),
      .fout  (fout)
   );

   csyn_testmux i_tmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .t_val     (t_val),
      .shift_msb (shift_msb),
      .ref_clk   (ref_clk),
      .m_pulse   (m_pulse),
      .fout      (fout),
      .test_out  (test_out)
   );

endmodule

// File: rtl/clksyn_ctrl_chk.sv
`timescale 1ns/1ps
module clksyn_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pload_n,
   input logic       ref_clk,
   input logic [2:0] t_val,
   input logic       sclk_rise,
   input logic       fout,
   input logic       test_out
);

   // R7
   pload_t_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pload_n |=> (t_val == 3'b000));

   // R4
   test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_val == 3'b000 || t_val == 3'b101 || t_val == 3'b111) |=> !test_out);

   // R4
   test_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_val == 3'b010) |=> (test_out == $past(ref_clk)));

   // R4
   test_fout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_val == 3'b100) |=> (test_out == $past(fout)));

   // R9
   bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_val == 3'b110 && !sclk_rise) |=> $stable(fout));

endmodule

bind clksyn_ctrl clksyn_ctrl_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pload_n   (pload_n),
   .ref_clk   (ref_clk),
   .t_val     (t_val),
   .sclk_rise (sclk_rise),
   .fout      (fout),
   .test_out  (test_out)
);

// File: tb/test_clksyn_ctrl.sv
`timescale 1ns/1ps
module test_clksyn_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic       sclk = 1'b0;
   logic       sdata = 1'b0;
   logic       sload = 1'b0;
   logic       pload_n = 1'b1;
   logic [8:0] pm = '0;
   logic [1:0] pn = '0;
   logic       fout;
   logic       test_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   clksyn_ctrl i_clksyn_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_clk  (ref_clk),
      .sclk     (sclk),
      .sdata    (sdata),
      .sload    (sload),
      .pload_n  (pload_n),
      .pm       (pm),
      .pn       (pn),
      .fout     (fout),
      .test_out (test_out)
   );

   function automatic int exp_period(input int m);
      return (m == 0) ? 1 : m;
   endfunction

   function automatic int exp_toggles(input int n, input int events);
      return events >> n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input bit b);
      @(negedge clk);
      sdata = b;
      sclk  = 1'b1;
      wait_cyc(4);
      sclk  = 1'b0;
      wait_cyc(4);
   endtask

   task automatic swrite(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
      logic [13:0] s;
      s = {t, n, m};
      for (int i = 13; i >= 0; i--) sbit(s[i]);
      sload = 1'b1;
      wait_cyc(4);
      sload = 1'b0;
      wait_cyc(4);
   endtask

   task automatic count_highs(input int win, output int c);
      c = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (test_out) c++;
      end
   endtask

   task automatic count_fout_edges(input int win, output int c);
      logic prev;
      c = 0;
      @(negedge clk);
      prev = fout;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (fout != prev) c++;
         prev = fout;
      end
   endtask

   task automatic check_m(input int m, input string req);
      int c;
      wait_cyc(80);
      count_highs(4 * exp_period(m), c);
      check(c == 4, req, c, 4);
   endtask

   task automatic check_n(input int n, input string req);
      int c;
      wait_cyc(20);
      count_fout_edges(64, c);
      check(c == exp_toggles(n, 64), req, c, exp_toggles(n, 64));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int c;
      int e;
      int mr;
      int nr;
      void'($urandom(32'd4321));

      // R1 reset state
      wait_cyc(3);
      check(fout == 1'b0, "R1 fout in reset", int'(fout), 0);
      check(test_out == 1'b0, "R1 test_out in reset", int'(test_out), 0);
      rst_n = 1'b1;
      // R1 reset N=00 gives a toggle every cycle, T=000 gives low test output
      check_n(0, "R1 reset N");
      count_highs(20, c);
      check(c == 0, "R1 reset T", c, 0);

      // R2 directed serial write, M pulse and N rate
      swrite(3'b011, 2'b10, 9'd7);
      check_m(7, "R2 M from serial");
      check_n(2, "R2 N from serial");

      // R5 M=0 and M=1 both continuous
      swrite(3'b011, 2'b00, 9'd0);
      check_m(0, "R5 M=0");
      count_highs(30, c);
      check(c == 30, "R5 M=0 level", c, 30);
      swrite(3'b011, 2'b00, 9'd1);
      check_m(1, "R5 M=1");

      // R3 leading junk bits are discarded
      sbit(1'b1);
      sbit(1'b1);
      sbit(1'b0);
      swrite(3'b011, 2'b11, 9'd5);
      check_m(5, "R3 junk discarded M");
      check_n(3, "R3 junk discarded N");

      // R5 R6 random configurations
      for (int it = 0; it < 8; it++) begin
         mr = $urandom % 48;
         nr = $urandom % 4;
         swrite(3'b011, nr[1:0], mr[8:0]);
         check_m(mr, "R5 random M");
         check_n(nr, "R6 random N");
      end

      // R4 shift register output walks the stream
      swrite(3'b001, 2'b10, 9'd5);
      wait_cyc(3);
      check(test_out == 1'b0, "R4 shift T2", int'(test_out), 0);
      sbit(1'b0);
      sbit(1'b0);
      check(test_out == 1'b1, "R4 shift T0", int'(test_out), 1);
      sbit(1'b0);
      check(test_out == 1'b1, "R4 shift N1", int'(test_out), 1);
      sbit(1'b0);
      check(test_out == 1'b0, "R4 shift N0", int'(test_out), 0);

      // R4 reference clock route
      swrite(3'b010, 2'b00, 9'd3);
      ref_clk = 1'b1;
      wait_cyc(3);
      check(test_out == 1'b1, "R4 ref high", int'(test_out), 1);
      ref_clk = 1'b0;
      wait_cyc(3);
      check(test_out == 1'b0, "R4 ref low", int'(test_out), 0);

      // R4 fout route with N=01
      swrite(3'b100, 2'b01, 9'd3);
      wait_cyc(20);
      e = 0;
      begin
         logic pv;
         @(negedge clk);
         pv = test_out;
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (test_out != pv) e++;
            pv = test_out;
         end
      end
      check(e == 32, "R4 fout route", e, 32);

      // R4 reserved codes give constant low
      ref_clk = 1'b1;
      swrite(3'b101, 2'b00, 9'd1);
      count_highs(30, c);
      check(c == 0, "R4 code 101 low", c, 0);
      swrite(3'b111, 2'b00, 9'd1);
      count_highs(30, c);
      check(c == 0, "R4 code 111 low", c, 0);

      // R9 R10 bypass: first settle M=3 in normal mode
      swrite(3'b011, 2'b00, 9'd3);
      wait_cyc(20);
      swrite(3'b110, 2'b00, 9'd3);
      begin
         logic pv;
         int   pulses;
         int   tog;
         pulses = 0;
         tog    = 0;
         pv     = fout;
         for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            sdata = 1'b0;
            sclk  = 1'b1;
            for (int k = 0; k < 8; k++) begin
               if (k == 4) sclk = 1'b0;
               @(negedge clk);
               if (test_out) pulses++;
               if (fout != pv) tog++;
               pv = fout;
            end
         end
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (test_out) pulses++;
            if (fout != pv) tog++;
            pv = fout;
         end
         check(pulses == 4, "R10 bypass M pulses", pulses, 4);
         check(tog == 12, "R10 bypass fout toggles N=00", tog, 12);
         // R9 no serial clock edges: outputs hold
         c = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (fout != pv) c++;
            if (test_out) c++;
         end
         check(c == 0, "R9 bypass hold", c, 0);
      end

      // R10 bypass with N=01: half the toggles
      swrite(3'b110, 2'b01, 9'd3);
      begin
         logic pv;
         int   tog;
         tog = 0;
         pv  = fout;
         for (int p = 0; p < 12; p++) begin
            sbit(1'b0);
            if (fout != pv) tog++;
            pv = fout;
         end
         check(tog == 6, "R10 bypass fout toggles N=01", tog, 6);
      end

      // R7 parallel load forces T low, N follows pins
      swrite(3'b010, 2'b00, 9'd3);
      ref_clk = 1'b1;
      wait_cyc(3);
      check(test_out == 1'b1, "R7 before pload", int'(test_out), 1);
      pn = 2'b10;
      pm = 9'd9;
      @(negedge clk);
      pload_n = 1'b0;
      wait_cyc(3);
      check(test_out == 1'b0, "R7 pload forces T", int'(test_out), 0);
      check_n(2, "R7 N follows pins");
      pn = 2'b01;
      check_n(1, "R7 N follows pin change");

      // R8 serial load during parallel load is ignored for T
      swrite(3'b010, 2'b00, 9'd3);
      @(negedge clk);
      pload_n = 1'b1;
      count_highs(30, c);
      check(c == 0, "R8 T stays 000 after release", c, 0);
      check_n(1, "R8 N kept from pins");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule